// File: doc/BRIEF.md
# Calendar Clock with Time-of-Day Alarm

This block keeps wall-clock time and a calendar date in byte registers and moves them forward by one second each time a one-cycle `sec_tick` pulse arrives. A tick opens a short update window; during that window a status bit warns software that the time bytes are about to change. The window closes with a single-cycle commit that loads the advanced time, carries through minutes, hours, weekday, date, month and year, and raises the update-done flag.

Software reaches every field through a byte-wide register port with a combinational read path. The time bytes hold either packed BCD or plain binary, and the hour byte holds either 24-hour or 12-hour form, both picked by control bits. A freeze bit lets software load a new time without a tick landing halfway through. Three alarm bytes are compared with the new time on every commit. Any alarm byte with both top bits set matches every value. Flag bits latch alarm hits and completed updates, and each flag can drive the interrupt line through its own enable.

Top module: `rtc_calendar`

## Requirements
- R1: Addresses 0 to 9 hold, in order: seconds, seconds alarm, minutes, minutes alarm, hours, hours alarm, weekday, date, month, year. Address 10 is status, 11 is control and 12 is flags. After reset the time is 00:00:00, weekday 1, date 1, month 1, year 0, control reads 0x02, flags read 0x00 and `irq` is 0.
- R2: Each committed update advances the time by exactly one second. Seconds and minutes wrap 59 to 0 and carry, and hours wrap 23 to 0 and carry into the date. Outside a commit, the time bytes change only on a register write.
- R3: The date wraps to 1 after the last day of its month. February has 29 days when the year is a multiple of 4 and 28 otherwise. The month wraps from 12 to 1, and the year wraps from 99 to 0.
- R4: The weekday counts 1 to 7 and steps on each date carry, wrapping from 7 to 1.
- R5: Control bit 2 selects the encoding of every time byte: 0 means packed BCD and 1 means binary.
- R6: Control bit 1 selects the hour format: 1 means 24-hour (0 to 23) and 0 means 12-hour. In 12-hour form the hour runs 1 to 12 and bit 7 of the hour byte is set for PM. 11 AM rolls to 12 PM, and 11 PM rolls to 12 AM with a date carry.
- R7: While control bit 7 (freeze) is 1, ticks start no update and the time bytes hold.
- R8: Status bit 7 reads 1 from the cycle after an accepted tick for UIP_CYCLES cycles. The new time appears UIP_CYCLES clock edges after the edge that samples the tick. A tick that arrives while a window is open is ignored.
- R9: On a commit, flag bit 5 sets when the seconds, minutes and hours bytes each equal their alarm byte. An alarm byte whose bits 7:6 are both 1 matches any value.
- R10: Flag bit 4 sets on every commit. Control bit 5 enables the alarm flag onto `irq`, and control bit 4 enables the update flag onto `irq`. Flag bit 7 mirrors `irq`. Any write to address 12 clears the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sec_tick | input | 1 | One-cycle pulse once per second |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| irq | output | 1 | Interrupt request: enabled flags ORed together |

## Verification
A register write lands on the edge that samples the strobe, and the read path is combinational, so a read in the next cycle already shows the written value. The update window opens one edge after the tick is sampled. The status bit is therefore checked two cycles after the tick pulse, and the time, flag and interrupt checks are made only after UIP_CYCLES further edges, once the commit has fallen. Every expected read goes into the scoreboard in the same cycle its address is driven, and the monitor compares it at the falling edge that follows, when no register can change.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int BYTE_W = 8;

  localparam int A_SEC   = 0;
  localparam int A_SEC_AL = 1;
  localparam int A_MIN   = 2;
  localparam int A_MIN_AL = 3;
  localparam int A_HOUR  = 4;
  localparam int A_HOUR_AL = 5;
  localparam int A_WDAY  = 6;
  localparam int A_DATE  = 7;
  localparam int A_MON   = 8;
  localparam int A_YEAR  = 9;
  localparam int A_STAT  = 10;
  localparam int A_CTRL  = 11;
  localparam int A_FLAG  = 12;

  typedef struct packed {
    logic [BYTE_W-1:0] sec;
    logic [BYTE_W-1:0] min;
    logic [BYTE_W-1:0] hour;
    logic [BYTE_W-1:0] wday;
    logic [BYTE_W-1:0] date;
    logic [BYTE_W-1:0] mon;
    logic [BYTE_W-1:0] year;
  } tod_t;

  function automatic logic [6:0] to_num(input logic [7:0] v, input logic bin);
    if (bin) return v[6:0];
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic [7:0] from_num(input logic [6:0] n, input logic bin);
    if (bin) return {1'b0, n};
    return {4'(n / 7'd10), 4'(n % 7'd10)};
  endfunction

  function automatic logic [6:0] month_len(input logic [6:0] mo, input logic [6:0] yr);
    case (mo)
      7'd2: return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11: return 7'd30;
      default: return 7'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_update_timer.sv
module rtc_update_timer #(
  parameter int UIP_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic commit
);
  localparam int CNT_W = $clog2(UIP_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else if (start)   cnt_d = CNT_W'(UIP_CYCLES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy   = (cnt_q != '0);
  assign commit = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/rtc_time_advance.sv
module rtc_time_advance
  import rtc_pkg::*;
(
  input  tod_t cur,
  input  logic bin_mode,
  input  logic h24_mode,
  output tod_t nxt
);
  logic [6:0] s, m, h, h12, w, d, mo, y, dim;
  logic [6:0] s_n, m_n, h_n, w_n, d_n, mo_n, y_n, h12_n;
  logic       c_min, c_hr, c_day, c_mon, c_yr;

  always_comb begin
    s  = to_num(cur.sec, bin_mode);
    m  = to_num(cur.min, bin_mode);
    w  = to_num(cur.wday, bin_mode);
    d  = to_num(cur.date, bin_mode);
    mo = to_num(cur.mon, bin_mode);
    y  = to_num(cur.year, bin_mode);
    h12 = to_num({1'b0, cur.hour[6:0]}, bin_mode);
    if (h24_mode) h = to_num(cur.hour, bin_mode);
    else          h = ((h12 == 7'd12) ? 7'd0 : h12) + (cur.hour[7] ? 7'd12 : 7'd0);
    dim = month_len(mo, y);

    c_min = (s >= 7'd59);
    c_hr  = c_min && (m >= 7'd59);
    c_day = c_hr && (h >= 7'd23);
    c_mon = c_day && (d >= dim);
    c_yr  = c_mon && (mo >= 7'd12);

    s_n  = c_min ? 7'd0 : s + 7'd1;
    m_n  = c_hr ? 7'd0 : (c_min ? m + 7'd1 : m);
    h_n  = c_day ? 7'd0 : (c_hr ? h + 7'd1 : h);
    d_n  = c_mon ? 7'd1 : (c_day ? d + 7'd1 : d);
    w_n  = c_day ? ((w >= 7'd7) ? 7'd1 : w + 7'd1) : w;
    mo_n = c_yr ? 7'd1 : (c_mon ? mo + 7'd1 : mo);
    y_n  = c_yr ? ((y >= 7'd99) ? 7'd0 : y + 7'd1) : y;
    h12_n = ((h_n % 7'd12) == 7'd0) ? 7'd12 : (h_n % 7'd12);

    nxt.sec  = from_num(s_n, bin_mode);
    nxt.min  = from_num(m_n, bin_mode);
    nxt.wday = from_num(w_n, bin_mode);
    nxt.date = from_num(d_n, bin_mode);
    nxt.mon  = from_num(mo_n, bin_mode);
    nxt.year = from_num(y_n, bin_mode);
    if (h24_mode) nxt.hour = from_num(h_n, bin_mode);
    else          nxt.hour = {(h_n >= 7'd12), from_num(h12_n, bin_mode)[6:0]};
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int FIELDS = 3,
  parameter int BYTE_W = 8
) (
  input  logic [FIELDS-1:0][BYTE_W-1:0] now_v,
  input  logic [FIELDS-1:0][BYTE_W-1:0] alarm_v,
  output logic                          hit
);
  logic [FIELDS-1:0] field_ok;

  for (genvar gi = 0; gi < FIELDS; gi++) begin : g_field
    assign field_ok[gi] = (alarm_v[gi][BYTE_W-1:BYTE_W-2] == 2'b11) ||
                          (alarm_v[gi] == now_v[gi]);
  end

  assign hit = &field_ok;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int UIP_CYCLES = 4,
  parameter int ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq
);
  localparam int ALARMS = 3;

  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  tod_t time_q, time_d, time_adv;
  logic [ALARMS-1:0][7:0] alarm_q, alarm_d;
  logic freeze_q, freeze_d, aie_q, aie_d, uie_q, uie_d;
  logic bin_q, bin_d, h24_q, h24_d;
  logic af_q, af_d, uf_q, uf_d;
  logic upd_busy, upd_commit, do_commit, alarm_hit;
  logic wr_flag;

  rtc_update_timer #(.UIP_CYCLES(UIP_CYCLES)) timer_i (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .start  (sec_tick && !freeze_q),
    .busy   (upd_busy),
    .commit (upd_commit)
  );

  rtc_time_advance adv_i (
    .cur      (time_q),
    .bin_mode (bin_q),
    .h24_mode (h24_q),
    .nxt      (time_adv)
  );

  rtc_alarm_match #(.FIELDS(ALARMS), .BYTE_W(8)) alarm_i (
    .now_v   ({time_adv.hour, time_adv.min, time_adv.sec}),
    .alarm_v (alarm_q),
    .hit     (alarm_hit)
  );

  assign do_commit = upd_commit && !freeze_q;
  assign wr_flag   = reg_wr && (reg_addr == ADDR_W'(A_FLAG));

  always_comb begin
    time_d   = do_commit ? time_adv : time_q;
    alarm_d  = alarm_q;
    freeze_d = freeze_q;
    aie_d    = aie_q;
    uie_d    = uie_q;
    bin_d    = bin_q;
    h24_d    = h24_q;
    if (reg_wr) begin
      case (reg_addr)
        ADDR_W'(A_SEC):     time_d.sec  = reg_wdata;
        ADDR_W'(A_MIN):     time_d.min  = reg_wdata;
        ADDR_W'(A_HOUR):    time_d.hour = reg_wdata;
        ADDR_W'(A_WDAY):    time_d.wday = reg_wdata;
        ADDR_W'(A_DATE):    time_d.date = reg_wdata;
        ADDR_W'(A_MON):     time_d.mon  = reg_wdata;
        ADDR_W'(A_YEAR):    time_d.year = reg_wdata;
        ADDR_W'(A_SEC_AL):  alarm_d[0]  = reg_wdata;
        ADDR_W'(A_MIN_AL):  alarm_d[1]  = reg_wdata;
        ADDR_W'(A_HOUR_AL): alarm_d[2]  = reg_wdata;
        ADDR_W'(A_CTRL): begin
          freeze_d = reg_wdata[7];
          aie_d    = reg_wdata[5];
          uie_d    = reg_wdata[4];
          bin_d    = reg_wdata[2];
          h24_d    = reg_wdata[1];
        end
        default: ;
      endcase
    end
    uf_d = (uf_q && !wr_flag) || do_commit;
    af_d = (af_q && !wr_flag) || (do_commit && alarm_hit);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      time_q   <= '{sec: 8'h00, min: 8'h00, hour: 8'h00, wday: 8'h01,
                    date: 8'h01, mon: 8'h01, year: 8'h00};
      alarm_q  <= '0;
      freeze_q <= 1'b0;
      aie_q    <= 1'b0;
      uie_q    <= 1'b0;
      bin_q    <= 1'b0;
      h24_q    <= 1'b1;
      af_q     <= 1'b0;
      uf_q     <= 1'b0;
    end else begin
      time_q   <= time_d;
      alarm_q  <= alarm_d;
      freeze_q <= freeze_d;
      aie_q    <= aie_d;
      uie_q    <= uie_d;
      bin_q    <= bin_d;
      h24_q    <= h24_d;
      af_q     <= af_d;
      uf_q     <= uf_d;
    end
  end

  assign irq = (af_q && aie_q) || (uf_q && uie_q);

  always_comb begin
    case (reg_addr)
      ADDR_W'(A_SEC):     reg_rdata = time_q.sec;
      ADDR_W'(A_SEC_AL):  reg_rdata = alarm_q[0];
      ADDR_W'(A_MIN):     reg_rdata = time_q.min;
      ADDR_W'(A_MIN_AL):  reg_rdata = alarm_q[1];
      ADDR_W'(A_HOUR):    reg_rdata = time_q.hour;
      ADDR_W'(A_HOUR_AL): reg_rdata = alarm_q[2];
      ADDR_W'(A_WDAY):    reg_rdata = time_q.wday;
      ADDR_W'(A_DATE):    reg_rdata = time_q.date;
      ADDR_W'(A_MON):     reg_rdata = time_q.mon;
      ADDR_W'(A_YEAR):    reg_rdata = time_q.year;
      ADDR_W'(A_STAT):    reg_rdata = {upd_busy, 7'b0};
      ADDR_W'(A_CTRL):    reg_rdata = {freeze_q, 1'b0, aie_q, uie_q, 1'b0, bin_q, h24_q, 1'b0};
      ADDR_W'(A_FLAG):    reg_rdata = {irq, 1'b0, af_q, uf_q, 4'b0};
      default:            reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sec_tick,
  input logic       freeze,
  input logic       uip,
  input logic       commit,
  input logic       uf,
  input logic       aie,
  input logic       uie,
  input logic       irq,
  input logic       reg_wr,
  input logic [7:0] sec_byte
);
  AST_FREEZE_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !uip) |=> !uip); // R7
  AST_TICK_OPENS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !freeze && !uip) |=> uip); // R8
  AST_COMMIT_INSIDE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> uip); // R8
  AST_UF_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> uf); // R10
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!aie && !uie) |-> !irq); // R10
  AST_SEC_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !reg_wr) |=> $stable(sec_byte)); // R2
endmodule

bind rtc_calendar rtc_calendar_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .sec_tick (sec_tick),
  .freeze   (freeze_q),
  .uip      (upd_busy),
  .commit   (do_commit),
  .uf       (uf_q),
  .aie      (aie_q),
  .uie      (uie_q),
  .irq      (irq),
  .reg_wr   (reg_wr),
  .sec_byte (time_q.sec)
);

// File: tb/rtc_calendar_tb_top.sv
`timescale 1ns/1ps
module rtc_calendar_tb_top;
  localparam int UIP = 4;

  logic       clk = 1'b0;
  logic       rst_n, sec_tick, reg_wr;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       irq;

  always #2 clk = ~clk;

  rtc_calendar #(.UIP_CYCLES(UIP), .ADDR_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  typedef struct {
    logic       is_irq;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sbq[$];
  int    checks = 0;
  int    fails  = 0;
  bit    finished = 0;

  always @(negedge clk) begin : monitor
    item_t      it;
    logic [7:0] act;
    if (sbq.size() > 0) begin
      it  = sbq.pop_front();
      act = it.is_irq ? {7'b0, irq} : reg_rdata;
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s actual=%02h expected=%02h", it.tag, act, it.exp);
      end
    end
  end

  task automatic exp_reg(input logic [3:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    reg_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic exp_irq(input logic e, input string tag);
    item_t it;
    @(posedge clk); #1;
    it.is_irq = 1'b1; it.exp = {7'b0, e}; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] s, m, h, w, d, mo, y);
    wr(4'd0, s); wr(4'd2, m); wr(4'd4, h);
    wr(4'd6, w); wr(4'd7, d); wr(4'd8, mo); wr(4'd9, y);
  endtask

  task automatic tick(input logic [7:0] uip_exp);
    @(posedge clk); #1;
    sec_tick = 1'b1;
    @(posedge clk); #1;
    sec_tick = 1'b0;
    exp_reg(4'd10, uip_exp, "R8 status during window");
    repeat (UIP + 1) @(posedge clk);
    exp_reg(4'd10, 8'h00, "R8 status after window");
  endtask

  initial begin : watchdog
    #(200000 * 4);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    rst_n = 1'b0; sec_tick = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    exp_reg(4'd0, 8'h00, "R1 seconds");
    exp_reg(4'd6, 8'h01, "R1 weekday");
    exp_reg(4'd7, 8'h01, "R1 date");
    exp_reg(4'd8, 8'h01, "R1 month");
    exp_reg(4'd11, 8'h02, "R1 control");
    exp_reg(4'd12, 8'h00, "R1 flags");
    exp_irq(1'b0, "R1 irq");

    // R7 freeze, then R2 R3 R4 full carry in BCD 24h
    wr(4'd11, 8'h82);
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23);
    tick(8'h00);
    exp_reg(4'd0, 8'h59, "R7 frozen seconds");
    wr(4'd11, 8'h02);
    tick(8'h80);
    exp_reg(4'd0, 8'h00, "R2 seconds wrap");
    exp_reg(4'd2, 8'h00, "R2 minutes wrap");
    exp_reg(4'd4, 8'h00, "R2 hours wrap");
    exp_reg(4'd7, 8'h01, "R3 non-leap Feb end");
    exp_reg(4'd8, 8'h03, "R3 month step");
    exp_reg(4'd6, 8'h01, "R4 weekday 7 to 1");
    exp_reg(4'd9, 8'h23, "R3 year held");

    // R3 leap year
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
    tick(8'h80);
    exp_reg(4'd7, 8'h29, "R3 leap Feb 29");
    exp_reg(4'd8, 8'h02, "R3 leap month held");
    exp_reg(4'd6, 8'h04, "R4 weekday step");
    // R3 year wrap
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h31, 8'h12, 8'h99);
    tick(8'h80);
    exp_reg(4'd9, 8'h00, "R3 year 99 to 0");
    exp_reg(4'd8, 8'h01, "R3 month 12 to 1");
    exp_reg(4'd7, 8'h01, "R3 date Dec 31 to 1");

    // R5 binary encoding
    wr(4'd11, 8'h06);
    set_time(8'h3B, 8'h3B, 8'h09, 8'h01, 8'h1F, 8'h01, 8'h63);
    tick(8'h80);
    exp_reg(4'd4, 8'h0A, "R5 binary hour carry");
    exp_reg(4'd7, 8'h1F, "R5 binary date held");
    set_time(8'h3B, 8'h3B, 8'h17, 8'h02, 8'h1F, 8'h01, 8'h63);
    tick(8'h80);
    exp_reg(4'd4, 8'h00, "R5 binary hour wrap");
    exp_reg(4'd7, 8'h01, "R5 binary Jan 31 to 1");
    exp_reg(4'd8, 8'h02, "R5 binary month");
    exp_reg(4'd6, 8'h03, "R5 binary weekday");

    // R6 12-hour BCD
    wr(4'd11, 8'h00);
    set_time(8'h59, 8'h59, 8'h11, 8'h01, 8'h10, 8'h05, 8'h20);
    tick(8'h80);
    exp_reg(4'd4, 8'h92, "R6 11AM to 12PM");
    exp_reg(4'd7, 8'h10, "R6 no date carry at noon");
    set_time(8'h59, 8'h59, 8'h91, 8'h01, 8'h10, 8'h05, 8'h20);
    tick(8'h80);
    exp_reg(4'd4, 8'h12, "R6 11PM to 12AM");
    exp_reg(4'd7, 8'h11, "R6 date carry at midnight");
    set_time(8'h59, 8'h59, 8'h12, 8'h01, 8'h10, 8'h05, 8'h20);
    tick(8'h80);
    exp_reg(4'd4, 8'h01, "R6 12AM to 1AM");

    // R9 R10 alarm and update flags
    wr(4'd11, 8'h22);
    wr(4'd1, 8'h05); wr(4'd3, 8'hC0); wr(4'd5, 8'hC0);
    set_time(8'h04, 8'h10, 8'h08, 8'h01, 8'h01, 8'h01, 8'h00);
    wr(4'd12, 8'h00);
    exp_reg(4'd12, 8'h00, "R10 flags cleared");
    tick(8'h80);
    exp_reg(4'd12, 8'hB0, "R9 alarm match with wildcards");
    exp_irq(1'b1, "R10 alarm irq enabled");
    wr(4'd12, 8'h00);
    exp_reg(4'd12, 8'h00, "R10 write clears flags");
    exp_irq(1'b0, "R10 irq after clear");
    wr(4'd1, 8'h30);
    tick(8'h80);
    exp_reg(4'd12, 8'h10, "R9 no alarm on mismatch");
    exp_irq(1'b0, "R10 update flag masked");
    wr(4'd11, 8'h12);
    exp_irq(1'b1, "R10 update irq enabled");
    exp_reg(4'd12, 8'h90, "R10 flag register with update irq");
    wr(4'd1, 8'h07); wr(4'd5, 8'h09); wr(4'd12, 8'h00);
    tick(8'h80);
    exp_reg(4'd12, 8'h90, "R9 hour alarm mismatch blocks alarm");

    repeat (3) @(posedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule